// File: doc/BRIEF.md
# Synchronous DRAM Burst Read Data Path

This block models the device side of a read from a two-bank synchronous DRAM with a 16-bit data bus. A controller opens a row in a bank, then issues read commands. Each read names a bank and a starting column. The block then produces a burst of words on the data bus. Each word is presented as a value together with one output-enable bit per byte, which stands for a tristate driver.

The delay from command to first word follows a configured latency of two or three clocks. The output enables open one cycle before the first word. Column addresses after the first are generated inside the block, one per clock. They wrap within the block of columns that is aligned to the burst length.

A full-page burst keeps running until it is stopped. It is stopped by a burst-stop command or by a newer read. A newer read takes over without a gap on the bus. Each output byte can be masked on its own by a mask input, which acts two cycles after it is sampled. The stored data is a small behavioural array whose contents are a fixed function of the location.

Top module: `sdr_read_path`

## Requirements
- R1: After a synchronous reset, `dq_oe` and `dq_out` are zero, `rd_err` is low, and no bank is open.
- R2: Commands are encoded on `cmd` as 0 idle, 1 open row, 2 read, 3 burst stop, 4 close bank. An open-row command marks bank `bank` open with row `addr[1:0]`, and a close command marks it closed for later reads. A read to a closed bank sets `rd_err`, which then stays high until reset. Such a read causes no bus activity and leaves any running burst untouched.
- R3: For a read sampled at clock edge T, the word at the start column appears on `dq_out` after edge T+2 when `cfg_cl3` is 0, or after edge T+3 when it is 1. Each later word follows one edge later.
- R4: The byte enables rise one edge before the first word, that is after edge T+1 or T+3−1. During that preamble cycle `dq_out` is zero.
- R5: `cfg_bl` codes 0, 1, 2 and 3 select bursts of 1, 2, 4 and 8 words. Any code with bit 2 set selects a full page of 256 columns. Word k of a burst reads column (start & ~(L−1)) | ((start+k) & (L−1)), where L is the burst length.
- R6: After the last word of a finite burst, the enables and `dq_out` return to zero at the next edge. Whenever no word is being presented, `dq_out` is zero.
- R7: A full-page burst continues and wraps until a stop or another read arrives. For a burst stop sampled at edge S, the last word appears after edge S+CL−1 and the enables drop after edge S+CL.
- R8: A high `dqm[b]` sampled at edge M forces `dq_oe[b]` low after edge M+2, for either latency. Bit b covers `dq_out[8b+7:8b]`, and `dq_out` itself still carries the word.
- R9: A valid read sampled at edge T′ during a burst ends the old burst's column generation. The old words generated before T′ still appear, and the new first word follows after edge T′+CL, with no gap between them.
- R10: The word stored at bank b, row r, column c is the low 16 bits of ({b,r,c} × 0x9E37) XOR 0x5A5A, where {b,r,c} is a 16-bit value with zeros above.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 3 | Command code, sampled every edge |
| bank | input | 1 | Bank selected by the command |
| addr | input | 8 | Row (low bits) for open-row, start column for read |
| cfg_cl3 | input | 1 | 0: latency 2, 1: latency 3 |
| cfg_bl | input | 3 | Burst length code |
| dqm | input | 2 | Per-byte output mask |
| dq_out | output | 16 | Data word presented on the bus |
| dq_oe | output | 2 | Per-byte driver enable |
| rd_err | output | 1 | Sticky flag for a read to a closed bank |

## Verification
The bench builds the block with its default parameters: 16-bit data, two banks, four rows and 256 columns. The 256-column page makes a full-page burst long enough to cross its wrap point in a directed run. The small array lets random reads reach every bank and row combination many times. Both latencies and all five burst-length choices are crossed with byte masks, interrupting reads, stops and reads to closed banks. These combinations cover preamble, drain and seam timing for each setting.

// File: rtl/sdr_pkg.sv
package sdr_pkg;

  typedef enum logic [2:0] {
    CMD_IDLE  = 3'd0,
    CMD_OPEN  = 3'd1,
    CMD_READ  = 3'd2,
    CMD_STOP  = 3'd3,
    CMD_CLOSE = 3'd4
  } sdr_cmd_e;

  // Fixed content of a location, indexed by {bank,row,col}.
  function automatic logic [31:0] fill_word(input logic [31:0] loc);
    return (loc * 32'h0000_9E37) ^ 32'h0000_5A5A;
  endfunction

endpackage

// File: rtl/sdr_bank_ctrl.sv
module sdr_bank_ctrl #(
  parameter int BANKS  = 2,
  parameter int ROW_W  = 2,
  parameter int BANK_W = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              is_open,
  input  logic              is_close,
  input  logic              is_read,
  input  logic [BANK_W-1:0] bank,
  input  logic [ROW_W-1:0]  row_in,
  output logic              bank_ok,
  output logic [ROW_W-1:0]  row_out,
  output logic              rd_err
);

  logic [BANKS-1:0] open_vec;
  logic [ROW_W-1:0] row_vec [BANKS];
  logic             err_q;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic             open_r;
    logic [ROW_W-1:0] row_r;
    logic             hit;

    assign hit = (bank == BANK_W'(b));

    always_ff @(posedge clk) begin
      if (rst) begin
        open_r <= 1'b0;
      end else if (is_open && hit) begin
        open_r <= 1'b1;
      end else if (is_close && hit) begin
        open_r <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (is_open && hit) begin
        row_r <= row_in;
      end
    end

    assign open_vec[b] = open_r;
    assign row_vec[b]  = row_r;
  end

  assign bank_ok = open_vec[bank];
  assign row_out = row_vec[bank];

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q <= 1'b0;
    end else if (is_read && !bank_ok) begin
      err_q <= 1'b1;
    end
  end

  assign rd_err = err_q;

endmodule

// File: rtl/sdr_burst_gen.sv
module sdr_burst_gen #(
  parameter  int COL_W  = 8,
  parameter  int ROW_W  = 2,
  parameter  int BANK_W = 1,
  localparam int AW     = BANK_W + ROW_W + COL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              stop,
  input  logic [BANK_W-1:0] start_bank,
  input  logic [ROW_W-1:0]  start_row,
  input  logic [COL_W-1:0]  start_col,
  input  logic              cfg_cl3,
  input  logic [2:0]        cfg_bl,
  output logic              iss_valid,
  output logic [AW-1:0]     iss_addr,
  output logic              iss_cl3
);

  logic              act_q;
  logic              full_q;
  logic              cl3_q;
  logic [COL_W-1:0]  col_q;
  logic [COL_W-1:0]  left_q;
  logic [COL_W-1:0]  wrap_q;
  logic [BANK_W-1:0] bank_q;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  len_mask;
  logic [COL_W-1:0]  col_next;

  // Length minus one doubles as the wrap mask of the aligned block.
  always_comb begin
    if (cfg_bl[2]) begin
      len_mask = '1;
    end else begin
      len_mask = COL_W'((32'd1 << cfg_bl[1:0]) - 32'd1);
    end
  end

  assign col_next = (col_q & ~wrap_q) | ((col_q + 1'b1) & wrap_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b0;
      full_q <= 1'b0;
      cl3_q  <= 1'b0;
      col_q  <= '0;
      left_q <= '0;
      wrap_q <= '0;
      bank_q <= '0;
      row_q  <= '0;
    end else if (start) begin
      act_q  <= 1'b1;
      full_q <= cfg_bl[2];
      cl3_q  <= cfg_cl3;
      col_q  <= start_col;
      left_q <= len_mask;
      wrap_q <= len_mask;
      bank_q <= start_bank;
      row_q  <= start_row;
    end else if (stop) begin
      act_q <= 1'b0;
    end else if (act_q) begin
      if (!full_q && left_q == '0) begin
        act_q <= 1'b0;
      end else begin
        col_q  <= col_next;
        left_q <= left_q - 1'b1;
      end
    end
  end

  assign iss_valid = act_q;
  assign iss_addr  = {bank_q, row_q, col_q};
  assign iss_cl3   = cl3_q;

endmodule

// File: rtl/sdr_array.sv
module sdr_array #(
  parameter  int AW    = 11,
  parameter  int DW    = 16,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          in_cl3,
  input  logic [AW-1:0] in_addr,
  output logic          out_valid,
  output logic          out_cl3,
  output logic [DW-1:0] out_data
);

  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = DW'(sdr_pkg::fill_word(32'(i)));
    end
  end

  // Unconditional registered read keeps the array block-RAM shaped.
  always_ff @(posedge clk) begin
    out_data <= mem[in_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_cl3   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      out_cl3   <= in_cl3;
    end
  end

endmodule

// File: rtl/sdr_out_pipe.sv
module sdr_out_pipe #(
  parameter  int DW    = 16,
  localparam int BYTES = DW / 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             iss_valid,
  input  logic             iss_cl3,
  input  logic             m_valid,
  input  logic             m_cl3,
  input  logic [DW-1:0]    m_data,
  input  logic [BYTES-1:0] dqm,
  output logic [DW-1:0]    dq_out,
  output logic [BYTES-1:0] dq_oe
);

  logic [DW-1:0]    d3_q;
  logic             v3_q;
  logic [BYTES-1:0] mask1_q;
  logic [BYTES-1:0] mask2_q;
  logic             out_hit;
  logic             pre_hit;
  logic             drive;
  logic [DW-1:0]    out_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      v3_q <= 1'b0;
    end else begin
      v3_q <= m_valid & m_cl3;
    end
  end

  always_ff @(posedge clk) begin
    d3_q    <= m_data;
    mask1_q <= dqm;
    mask2_q <= mask1_q;
  end

  // Word due at this edge, and word due at the next one (preamble).
  assign out_hit  = (m_valid & ~m_cl3) | v3_q;
  assign out_word = v3_q ? d3_q : m_data;
  assign pre_hit  = (iss_valid & ~iss_cl3) | (m_valid & m_cl3);
  assign drive    = out_hit | pre_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      dq_out <= '0;
    end else begin
      dq_out <= out_hit ? out_word : '0;
    end
  end

  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        dq_oe[b] <= 1'b0;
      end else begin
        dq_oe[b] <= drive & ~mask2_q[b];
      end
    end
  end

endmodule

// File: rtl/sdr_read_path.sv
module sdr_read_path #(
  parameter  int DATA_W = 16,
  parameter  int BANKS  = 2,
  parameter  int ROW_W  = 2,
  parameter  int COL_W  = 8,
  localparam int BYTES  = DATA_W / 8,
  localparam int BANK_W = $clog2(BANKS),
  localparam int AW     = BANK_W + ROW_W + COL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        cmd,
  input  logic [BANK_W-1:0] bank,
  input  logic [COL_W-1:0]  addr,
  input  logic              cfg_cl3,
  input  logic [2:0]        cfg_bl,
  input  logic [BYTES-1:0]  dqm,
  output logic [DATA_W-1:0] dq_out,
  output logic [BYTES-1:0]  dq_oe,
  output logic              rd_err
);

  import sdr_pkg::*;

  logic             is_open;
  logic             is_close;
  logic             is_read;
  logic             is_stop;
  logic             bank_ok;
  logic [ROW_W-1:0] row_sel;
  logic             iss_valid;
  logic             iss_cl3;
  logic [AW-1:0]    iss_addr;
  logic             m_valid;
  logic             m_cl3;
  logic [DATA_W-1:0] m_data;

  assign is_open  = (cmd == CMD_OPEN);
  assign is_close = (cmd == CMD_CLOSE);
  assign is_read  = (cmd == CMD_READ);
  assign is_stop  = (cmd == CMD_STOP);

  sdr_bank_ctrl #(.BANKS(BANKS), .ROW_W(ROW_W), .BANK_W(BANK_W)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .is_open (is_open),
    .is_close(is_close),
    .is_read (is_read),
    .bank    (bank),
    .row_in  (addr[ROW_W-1:0]),
    .bank_ok (bank_ok),
    .row_out (row_sel),
    .rd_err  (rd_err)
  );

  sdr_burst_gen #(.COL_W(COL_W), .ROW_W(ROW_W), .BANK_W(BANK_W)) u_gen (
    .clk       (clk),
    .rst       (rst),
    .start     (is_read & bank_ok),
    .stop      (is_stop),
    .start_bank(bank),
    .start_row (row_sel),
    .start_col (addr),
    .cfg_cl3   (cfg_cl3),
    .cfg_bl    (cfg_bl),
    .iss_valid (iss_valid),
    .iss_addr  (iss_addr),
    .iss_cl3   (iss_cl3)
  );

  sdr_array #(.AW(AW), .DW(DATA_W)) u_array (
    .clk      (clk),
    .rst      (rst),
    .in_valid (iss_valid),
    .in_cl3   (iss_cl3),
    .in_addr  (iss_addr),
    .out_valid(m_valid),
    .out_cl3  (m_cl3),
    .out_data (m_data)
  );

  sdr_out_pipe #(.DW(DATA_W)) u_out (
    .clk      (clk),
    .rst      (rst),
    .iss_valid(iss_valid),
    .iss_cl3  (iss_cl3),
    .m_valid  (m_valid),
    .m_cl3    (m_cl3),
    .m_data   (m_data),
    .dqm      (dqm),
    .dq_out   (dq_out),
    .dq_oe    (dq_oe)
  );

endmodule

// File: rtl/sdr_read_path_chk.sv
module sdr_read_path_chk #(
  parameter int BYTES = 2
) (
  input logic             clk,
  input logic             rst,
  input logic [2:0]       cmd,
  input logic             bank_ok,
  input logic             iss_valid,
  input logic             rd_err,
  input logic [BYTES-1:0] dqm,
  input logic [BYTES-1:0] dq_oe
);

  // R2
  err_set_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd == 3'd2 && !bank_ok) |=> rd_err);

  // R2
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    rd_err |=> rd_err);

  // R7
  stop_halts_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd == 3'd3) |=> !iss_valid);

  for (genvar b = 0; b < BYTES; b++) begin : g_mask
    // R8
    mask_delay_chk: assert property (@(posedge clk) disable iff (rst)
      dqm[b] |-> ##3 !dq_oe[b]);
  end

endmodule

bind sdr_read_path sdr_read_path_chk #(.BYTES(BYTES)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cmd      (cmd),
  .bank_ok  (bank_ok),
  .iss_valid(iss_valid),
  .rd_err   (rd_err),
  .dqm      (dqm),
  .dq_oe    (dq_oe)
);

// File: tb/tb_sdr_read_path.sv
module tb_sdr_read_path;

  localparam int CLK_PERIOD = 10;
  localparam int RING       = 1024;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  cmd = 3'd0;
  logic        bank = 1'b0;
  logic [7:0]  addr = 8'd0;
  logic        cfg_cl3 = 1'b0;
  logic [2:0]  cfg_bl = 3'd2;
  logic [1:0]  dqm = 2'b00;
  logic [15:0] dq_out;
  logic [1:0]  dq_oe;
  logic        rd_err;

  sdr_read_path dut (
    .clk(clk), .rst(rst), .cmd(cmd), .bank(bank), .addr(addr),
    .cfg_cl3(cfg_cl3), .cfg_bl(cfg_bl), .dqm(dqm),
    .dq_out(dq_out), .dq_oe(dq_oe), .rd_err(rd_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit done   = 0;
  string phase = "R1 reset";

  // Expected schedule, indexed by output edge modulo RING.
  bit          sv [RING];
  logic [15:0] sd [RING];
  logic [1:0]  mh [RING];
  bit          m_open [2];
  logic [1:0]  m_row  [2];
  bit          m_err = 0;
  int          cur_end = -1;
  int          cur_cl  = 2;
  int          last_start = 0;

  function automatic logic [15:0] word(bit b, logic [1:0] r, logic [7:0] c);
    logic [15:0] a;
    a = {5'd0, b, r, c};
    return (a * 16'h9E37) ^ 16'h5A5A;
  endfunction

  task automatic chk(string what, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h (cycle %0d)", what, got, exp, cyc);
    end
  endtask

  task automatic cut(int e);
    for (int t = e + cur_cl; t <= cur_end + cur_cl; t++) sv[t % RING] = 0;
    if (cur_end >= e) cur_end = e - 1;
  endtask

  task automatic sched(int e);
    int cl, n, msk;
    cl  = cfg_cl3 ? 3 : 2;
    n   = cfg_bl[2] ? 600 : (1 << cfg_bl[1:0]);
    msk = cfg_bl[2] ? 255 : n - 1;
    for (int k = 0; k < n; k++) begin
      logic [7:0] c;
      c = 8'((int'(addr) & ~msk) | ((int'(addr) + k) & msk));
      sv[(e + cl + k) % RING] = 1;
      sd[(e + cl + k) % RING] = word(bank, m_row[bank], c);
    end
    cur_cl = cl;
    cur_end = e + n - 1;
    last_start = e;
  endtask

  task automatic model_edge(int e);
    mh[e % RING] = dqm;
    case (cmd)
      3'd1: begin m_open[bank] = 1; m_row[bank] = addr[1:0]; end
      3'd4: m_open[bank] = 0;
      3'd3: cut(e);
      3'd2: begin
        if (!m_open[bank]) m_err = 1;
        else begin cut(e); sched(e); end
      end
      default: ;
    endcase
  endtask

  task automatic check_cycle(int e);
    bit drive;
    logic [1:0] msk;
    drive = sv[e % RING] | sv[(e + 1) % RING];
    msk = (e >= 2) ? mh[(e - 2) % RING] : 2'b00;
    chk({phase, " R8 byte enables"}, 32'(dq_oe), 32'({2{drive}} & ~msk));
    chk({phase, " R10 data"}, 32'(dq_out), sv[e % RING] ? 32'(sd[e % RING]) : 32'd0);
    chk({phase, " R2 error flag"}, 32'(rd_err), 32'(m_err));
    sv[e % RING] = 0;
  endtask

  task automatic tick(logic [2:0] c, bit b, logic [7:0] a, logic [1:0] m);
    cmd = c; bank = b; addr = a; dqm = m;
    model_edge(cyc + 1);
    @(posedge clk);
    cyc++;
    @(negedge clk);
    check_cycle(cyc);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick(3'd0, 0, 8'd0, 2'b00);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    phase = "R1 reset";
    chk("R1 reset dq_oe", 32'(dq_oe), 32'd0);
    chk("R1 reset dq_out", 32'(dq_out), 32'd0);
    chk("R1 reset rd_err", 32'(rd_err), 32'd0);
    rst = 1'b0;

    // R1 / R2: no bank open after reset, so a read flags an error.
    phase = "R2 closed bank";
    tick(3'd2, 0, 8'h05, 2'b00);
    idle(4);
    chk("R2 sticky error after closed read", 32'(rd_err), 32'd1);

    tick(3'd1, 0, 8'h01, 2'b00);
    tick(3'd1, 1, 8'h02, 2'b00);

    phase = "R3 R5 R6 cl2 len4";
    cfg_cl3 = 0; cfg_bl = 3'd2;
    tick(3'd2, 0, 8'h0E, 2'b00);
    idle(7);

    phase = "R4 cl3 len8";
    cfg_cl3 = 1; cfg_bl = 3'd3;
    tick(3'd2, 1, 8'h35, 2'b00);
    idle(13);

    phase = "R5 len1 len2";
    cfg_cl3 = 0; cfg_bl = 3'd0;
    tick(3'd2, 0, 8'h77, 2'b00);
    idle(4);
    cfg_cl3 = 1; cfg_bl = 3'd1;
    tick(3'd2, 1, 8'h81, 2'b00);
    idle(6);

    phase = "R8 masks";
    for (int l = 0; l < 2; l++) begin
      cfg_cl3 = l[0]; cfg_bl = 3'd3;
      tick(3'd2, 0, 8'h40, 2'b01);
      tick(3'd0, 0, 8'h00, 2'b10);
      tick(3'd0, 0, 8'h00, 2'b11);
      tick(3'd0, 0, 8'h00, 2'b00);
      tick(3'd0, 0, 8'h00, 2'b01);
      tick(3'd0, 0, 8'h00, 2'b00);
      tick(3'd0, 0, 8'h00, 2'b10);
      idle(8);
    end

    phase = "R7 full page";
    cfg_cl3 = 0; cfg_bl = 3'd7;
    tick(3'd2, 0, 8'hFE, 2'b00);
    idle(270);
    tick(3'd3, 0, 8'h00, 2'b00);
    idle(6);
    cfg_cl3 = 1;
    tick(3'd2, 1, 8'h10, 2'b00);
    idle(20);
    tick(3'd3, 0, 8'h00, 2'b00);
    idle(6);

    phase = "R9 interrupt";
    cfg_cl3 = 0; cfg_bl = 3'd3;
    tick(3'd2, 0, 8'h10, 2'b00);
    idle(3);
    tick(3'd2, 1, 8'h20, 2'b00);
    idle(12);
    cfg_cl3 = 1;
    tick(3'd2, 1, 8'h2C, 2'b00);
    idle(2);
    tick(3'd2, 0, 8'h93, 2'b00);
    idle(14);

    phase = "R2 close during burst";
    cfg_cl3 = 0; cfg_bl = 3'd3;
    tick(3'd2, 0, 8'h08, 2'b00);
    tick(3'd4, 1, 8'h00, 2'b00);
    tick(3'd2, 1, 8'h09, 2'b00);
    idle(10);
    tick(3'd1, 1, 8'h03, 2'b00);

    phase = "R5 R9 random";
    for (int i = 0; i < 4000; i++) begin
      int r;
      logic [1:0] m;
      if (i % 500 == 0) begin
        int idx;
        tick(3'd3, 0, 8'h00, 2'b00);
        idle(6);
        idx = $urandom % 5;
        cfg_bl = (idx == 4) ? 3'd7 : 3'(idx);
        cfg_cl3 = $urandom % 2;
      end
      m = (($urandom % 4) == 0) ? 2'($urandom) : 2'b00;
      if (cur_end >= cyc && (cyc - last_start) > 500) begin
        tick(3'd3, 0, 8'h00, m);
      end else begin
        r = $urandom % 16;
        if (r >= 8 && r <= 10) tick(3'd2, 1'($urandom), 8'($urandom), m);
        else if (r == 11) tick(3'd3, 0, 8'h00, m);
        else if (r == 12) tick(3'd1, 1'($urandom), 8'($urandom), m);
        else if (r == 13 && ($urandom % 4) == 0) tick(3'd4, 1'($urandom), 8'h00, m);
        else tick(3'd0, 0, 8'h00, m);
      end
    end
    tick(3'd3, 0, 8'h00, 2'b00);
    idle(6);
    summary();
  end

endmodule